// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Self-Refresh Sequencer

This block owns the refresh strobes of an EDO DRAM. A periodic refresh tick causes a short CAS-before-RAS (CBR) refresh cycle. A sleep request from the power manager parks the memory in self refresh. The block first lowers CAS, then lowers RAS, and keeps both low past the programmed minimum holds. It then releases CAS and keeps RAS low until a wake request arrives. On wake it raises RAS and holds it high for the programmed exit time before it hands the bus back.

The block shares the RAS/CAS pins with an access controller. It raises `bus_req` and waits for `bus_gnt` before it moves either strobe. It keeps `bus_req` high until its strobe sequence is complete. From the moment it accepts a sleep request until the exit time has run out, `busy` stays high, and the access controller must keep off the memory for that whole time. Every timing value is a cycle count on an input port. A count of zero behaves as one cycle.

Top module: `sr_cbr_sequencer`

## Requirements
- R1: During and straight after reset, `ras_n` and `cas_n` are 1, and `bus_req`, `busy` and `sr_active` are 0.
- R2: A refresh tick sampled while the block is idle raises `bus_req` in the next cycle. Both strobes stay high for as long as `bus_gnt` is 0.
- R3: Once granted, a refresh drives CAS low alone for `t_csr` cycles, then both strobes low for `t_ras` cycles, then both high for `t_rp` cycles with `bus_req` still 1. After that `bus_req` falls. RAS never falls unless CAS was already low.
- R4: A refresh tick that arrives during a refresh cycle is held, one deep. A second refresh cycle starts after a single idle cycle.
- R5: A sleep request sampled while idle raises `busy` and `bus_req` in the next cycle. Sleep takes priority over a refresh tick sampled in the same cycle, and that tick is dropped.
- R6: Self-refresh entry drives CAS low alone for `t_csr` cycles, then both strobes low for `t_chd` cycles, then CAS high with RAS still low. `sr_active` is 1 exactly while RAS is low during self refresh.
- R7: RAS stays low for at least `t_rass` cycles in self refresh. A wake request that arrives earlier waits, and RAS rises in the first cycle after that minimum is reached.
- R8: After the minimum holds are met, RAS rises two cycles after the cycle in which `wake_req` is sampled.
- R9: On exit, RAS is high for `t_rps` cycles while `busy` and `bus_req` stay 1. Both then fall together.
- R10: Refresh ticks sampled between sleep acceptance and the end of the exit time are dropped. No refresh cycle follows the exit because of them.
- R11: A wake request sampled while idle has no effect. It does not shorten the next self refresh.
- R12: The first refresh after a self-refresh exit is a CBR cycle, with CAS falling before RAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Level request to enter self refresh, taken when idle |
| wake_req | input | 1 | Request to leave self refresh |
| refresh_tick | input | 1 | Periodic refresh demand |
| bus_gnt | input | 1 | Access controller grants the strobe pins |
| t_csr | input | CNT_W | CAS-to-RAS lead, in cycles |
| t_ras | input | CNT_W | RAS-low time of a normal refresh |
| t_rp | input | CNT_W | Precharge time after a normal refresh |
| t_chd | input | CNT_W | Minimum CAS-low hold on self-refresh entry |
| t_rass | input | CNT_W | Minimum RAS-low time in self refresh |
| t_rps | input | CNT_W | Minimum RAS-high time on self-refresh exit |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| bus_req | output | 1 | Request for the strobe pins |
| busy | output | 1 | Self-refresh sequence in progress; access controller holds off |
| sr_active | output | 1 | Memory is in self refresh |

## Verification
A phase counter that is wrong by one shows as a strobe edge one cycle early or late. The per-cycle comparison catches this in the cycle where it happens. A stale wake or refresh flag shows only later: it cuts the next self-refresh stay short, or it starts an unwanted refresh after exit. The bench therefore follows each such stimulus with a complete later sequence and checks every cycle of that sequence. A hold meter that fails to clear shows as RAS rising too soon on the next sleep.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_RRAS,
        ST_RPRE,
        ST_SBOTH,
        ST_SRAS,
        ST_SEXIT
    } seq_state_e;

    typedef enum logic {
        OP_REF,
        OP_SLEEP
    } seq_op_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic req;
        logic busy;
        logic sr;
    } pins_t;

    // Pin values for a given state and operation.
    function automatic pins_t decode_pins(seq_state_e st, seq_op_e op);
        pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, req: 1'b0, busy: 1'b0, sr: 1'b0};
        case (st)
            ST_IDLE: ;
            ST_WAIT: begin
                p.req  = 1'b1;
                p.busy = (op == OP_SLEEP);
            end
            ST_LEAD: begin
                p.req   = 1'b1;
                p.cas_n = 1'b0;
                p.busy  = (op == OP_SLEEP);
            end
            ST_RRAS: begin
                p.req   = 1'b1;
                p.cas_n = 1'b0;
                p.ras_n = 1'b0;
            end
            ST_RPRE: p.req = 1'b1;
            ST_SBOTH: begin
                p.req   = 1'b1;
                p.busy  = 1'b1;
                p.cas_n = 1'b0;
                p.ras_n = 1'b0;
                p.sr    = 1'b1;
            end
            ST_SRAS: begin
                p.req   = 1'b1;
                p.busy  = 1'b1;
                p.ras_n = 1'b0;
                p.sr    = 1'b1;
            end
            ST_SEXIT: begin
                p.req  = 1'b1;
                p.busy = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sr_phase_timer.sv
// Down counter: a load of N gives a phase that lasts max(N,1) cycles.
module sr_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sr_hold_meter.sv
// Counts cycles spent with RAS low in self refresh, saturating.
module sr_hold_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         met
);
    logic [W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            age <= '0;
        end else if (age != {W{1'b1}}) begin
            age <= age + 1'b1;
        end
    end

    // Cycles so far, including the present one, compared with the limit.
    assign met = ({1'b0, age} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};
endmodule

// File: rtl/sr_flag.sv
// Sticky request flag; clear wins over set.
module sr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/sr_cbr_sequencer.sv
module sr_cbr_sequencer
    import srseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             refresh_tick,
    input  logic             bus_gnt,
    input  logic [CNT_W-1:0] t_csr,
    input  logic [CNT_W-1:0] t_ras,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_chd,
    input  logic [CNT_W-1:0] t_rass,
    input  logic [CNT_W-1:0] t_rps,
    output logic             ras_n,
    output logic             cas_n,
    output logic             bus_req,
    output logic             busy,
    output logic             sr_active
);
    seq_state_e       st, st_nx;
    seq_op_e          op, op_nx;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             hold_met;
    logic             ref_pend, wake_pend;
    logic             in_sleep, start_op;
    pins_t            pins_q;

    sr_phase_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    sr_hold_meter #(.W(CNT_W)) u_meter (
        .clk(clk), .rst(rst),
        .run(st == ST_SBOTH || st == ST_SRAS),
        .limit(t_rass), .met(hold_met)
    );

    assign in_sleep = (st != ST_IDLE) && (op == OP_SLEEP);
    assign start_op = (st == ST_IDLE) && (st_nx == ST_WAIT);

    sr_flag u_ref_flag (
        .clk(clk), .rst(rst),
        .set(refresh_tick && !in_sleep),
        .clr(start_op),
        .q(ref_pend)
    );

    sr_flag u_wake_flag (
        .clk(clk), .rst(rst),
        .set(wake_req && in_sleep && st != ST_SEXIT),
        .clr(st_nx == ST_SEXIT),
        .q(wake_pend)
    );

    always_comb begin
        st_nx  = st;
        op_nx  = op;
        t_load = 1'b0;
        t_val  = '0;
        case (st)
            ST_IDLE: begin
                if (sleep_req) begin
                    st_nx = ST_WAIT;
                    op_nx = OP_SLEEP;
                end else if (ref_pend || refresh_tick) begin
                    st_nx = ST_WAIT;
                    op_nx = OP_REF;
                end
            end
            ST_WAIT: begin
                if (bus_gnt) begin
                    st_nx  = ST_LEAD;
                    t_load = 1'b1;
                    t_val  = t_csr;
                end
            end
            ST_LEAD: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (op == OP_REF) begin
                        st_nx = ST_RRAS;
                        t_val = t_ras;
                    end else begin
                        st_nx = ST_SBOTH;
                        t_val = t_chd;
                    end
                end
            end
            ST_RRAS: begin
                if (t_done) begin
                    st_nx  = ST_RPRE;
                    t_load = 1'b1;
                    t_val  = t_rp;
                end
            end
            ST_RPRE: begin
                if (t_done) st_nx = ST_IDLE;
            end
            ST_SBOTH: begin
                if (t_done) st_nx = ST_SRAS;
            end
            ST_SRAS: begin
                if (wake_pend && hold_met) begin
                    st_nx  = ST_SEXIT;
                    t_load = 1'b1;
                    t_val  = t_rps;
                end
            end
            ST_SEXIT: begin
                if (t_done) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op     <= OP_REF;
            pins_q <= decode_pins(ST_IDLE, OP_REF);
        end else begin
            st     <= st_nx;
            op     <= op_nx;
            pins_q <= decode_pins(st_nx, op_nx);
        end
    end

    assign ras_n     = pins_q.ras_n;
    assign cas_n     = pins_q.cas_n;
    assign bus_req   = pins_q.req;
    assign busy      = pins_q.busy;
    assign sr_active = pins_q.sr;
endmodule

// File: rtl/sr_cbr_sequencer_chk.sv
module sr_cbr_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic bus_req,
    input logic busy,
    input logic sr_active
);
    // R3
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> ($past(!cas_n) && !cas_n));

    // R2
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> bus_req);

    // R5
    busy_holds_bus_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> bus_req);

    // R6
    sr_ras_low_chk: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> (!ras_n && busy));

    // R6
    cas_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_n) && !ras_n) |-> sr_active);

    // R9
    exit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && $past(sr_active)) |-> busy);
endmodule

bind sr_cbr_sequencer sr_cbr_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
    .bus_req(bus_req), .busy(busy), .sr_active(sr_active)
);

// File: tb/sr_cbr_sequencer_test.sv
`timescale 1ns/1ps
module sr_cbr_sequencer_test;
    localparam int CW = 8;
    localparam int CSR = 2, RAS = 3, RP = 2, CHD = 3, RASS = 6, RPS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 0, wake_req = 0, refresh_tick = 0, bus_gnt = 0;
    logic ras_n, cas_n, bus_req, busy, sr_active;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sr_cbr_sequencer #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .refresh_tick(refresh_tick), .bus_gnt(bus_gnt),
        .t_csr(CW'(CSR)), .t_ras(CW'(RAS)), .t_rp(CW'(RP)),
        .t_chd(CW'(CHD)), .t_rass(CW'(RASS)), .t_rps(CW'(RPS)),
        .ras_n(ras_n), .cas_n(cas_n), .bus_req(bus_req),
        .busy(busy), .sr_active(sr_active)
    );

    // One clock, then compare every output with the expected vector.
    task automatic step(input logic er, ec, eq, eb, es, input string tag);
        @(posedge clk);
        #2;
        checks++;
        if ({ras_n, cas_n, bus_req, busy, sr_active} !== {er, ec, eq, eb, es}) begin
            errors++;
            $display("FAIL %s: ras,cas,req,busy,sr = %b%b%b%b%b expected %b%b%b%b%b",
                     tag, ras_n, cas_n, bus_req, busy, sr_active, er, ec, eq, eb, es);
        end
    endtask

    task automatic hold(input int n, input logic er, ec, eq, eb, es, input string tag);
        for (int i = 0; i < n; i++) step(er, ec, eq, eb, es, tag);
    endtask

    // Full CBR refresh after the request cycle, granted at once.
    task automatic cbr_body(input string tag);
        hold(CSR, 1, 0, 1, 0, 0, tag);
        hold(RAS, 0, 0, 1, 0, 0, tag);
        hold(RP,  1, 1, 1, 0, 0, tag);
    endtask

    // Self-refresh entry after the request cycle: lead and both-low hold.
    task automatic sr_entry(input string tag);
        hold(CSR, 1, 0, 1, 1, 0, tag);
        hold(CHD, 0, 0, 1, 1, 1, tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        hold(3, 1, 1, 0, 0, 0, "R1");
        rst = 0;
        hold(2, 1, 1, 0, 0, 0, "R1");

        // R2: tick with grant withheld, strobes must not move
        refresh_tick = 1;
        step(1, 1, 1, 0, 0, "R2");
        refresh_tick = 0;
        hold(3, 1, 1, 1, 0, 0, "R2");
        bus_gnt = 1;
        // R3: complete CBR cycle
        cbr_body("R3");
        step(1, 1, 0, 0, 0, "R3");

        // R4: tick during a refresh is queued one deep
        refresh_tick = 1;
        step(1, 1, 1, 0, 0, "R4");
        refresh_tick = 0;
        step(1, 0, 1, 0, 0, "R4");
        refresh_tick = 1;
        step(1, 0, 1, 0, 0, "R4");
        refresh_tick = 0;
        hold(RAS, 0, 0, 1, 0, 0, "R4");
        hold(RP,  1, 1, 1, 0, 0, "R4");
        step(1, 1, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, "R4");
        cbr_body("R4");
        hold(2, 1, 1, 0, 0, 0, "R4");

        // R5: sleep and tick together; sleep wins
        sleep_req = 1;
        refresh_tick = 1;
        step(1, 1, 1, 1, 0, "R5");
        sleep_req = 0;
        refresh_tick = 0;
        // R6: entry order
        hold(CSR, 1, 0, 1, 1, 0, "R6");
        step(0, 0, 1, 1, 1, "R6");
        wake_req = 1;          // R7: early wake must wait
        step(0, 0, 1, 1, 1, "R7");
        wake_req = 0;
        step(0, 0, 1, 1, 1, "R6");
        refresh_tick = 1;      // R10: dropped during self refresh
        step(0, 1, 1, 1, 1, "R10");
        refresh_tick = 0;
        hold(RASS - CHD - 1, 0, 1, 1, 1, 1, "R7");
        // R9: exit time
        hold(RPS, 1, 1, 1, 1, 0, "R9");
        // R10: no refresh from the dropped ticks
        hold(4, 1, 1, 0, 0, 0, "R10");

        // R12: refresh after exit is CBR
        refresh_tick = 1;
        step(1, 1, 1, 0, 0, "R12");
        refresh_tick = 0;
        cbr_body("R12");
        step(1, 1, 0, 0, 0, "R12");

        // R11: wake while idle is ignored
        wake_req = 1;
        step(1, 1, 0, 0, 0, "R11");
        wake_req = 0;
        hold(2, 1, 1, 0, 0, 0, "R11");

        // R8: late wake; a stale wake flag would end this early (R11)
        sleep_req = 1;
        step(1, 1, 1, 1, 0, "R5");
        sleep_req = 0;
        sr_entry("R6");
        hold(8, 0, 1, 1, 1, 1, "R11");
        wake_req = 1;
        step(0, 1, 1, 1, 1, "R8");
        wake_req = 0;
        hold(RPS, 1, 1, 1, 1, 0, "R8");
        hold(3, 1, 1, 0, 0, 0, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule